// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers up to 64 level-sensitive interrupt requests, lets software enable or disable each one, and picks a single winning source for each of two CPU interrupt lines: a low line and a high line. Sources are arranged in six groups of eight: W, X, Y, Z, RISC A and RISC B. Inside a group, software ranks sources by writing a source's 3-bit code into one of eight priority slots. Each group is resolved either as a block (grouped mode) or with its slots interleaved among the other spread-mode groups (spread mode).

One programmable source can be lifted above every group winner and sent to either line. The top two slots of every group can also be steered to the high line. A 32-bit register port holds the control, mask, routing and per-group priority registers, plus two read-only vector registers that report the current winner for each line. Sources are held by their devices until serviced; the block keeps no pending state of its own beyond a one-flop input sample.

Group g (W=0, X=1, Y=2, Z=3, RISC A=4, RISC B=5) owns source numbers 8(g+1) to 8(g+1)+7, and code c of that group is source 8(g+1)+c. Sources 1 to 7 and 56 to 63 belong to no group. Source 0 does not exist.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all masks, control fields, priority slots and routing fields read as zero, both interrupt outputs are low and both vector registers read zero, even with every source asserted.
- R2: A source takes part only while its mask bit is 1. Sources 0..31 use bit n of word 1, and sources 32..63 use bit n-32 of word 2.
- R3: Vector register reads (word 4 low, word 5 high) return the winning source number in bits 31:26 and zero elsewhere. The value 0 means no winner.
- R4: The priority register of group g is word 8+g. Slot p (1..8) is the 3-bit field at bit 32-3p for p<4 and 24-3p for p>=4. Within a group, the source in the lowest-numbered slot wins. A code present in several slots counts at its lowest slot. Codes in no slot lose to every slotted source, and among themselves the lower code wins.
- R5: In grouped mode, all slotted sources of a lower-indexed group beat those of a higher-indexed group (W first, RISC B last).
- R6: Control bit 16+g puts group g in spread mode. Spread groups rank by slot first and group second. A slotted entry's rank is 8*group+(slot-1) when grouped and 8*(slot-1)+group when spread, the lower rank wins, and equal ranks go to the lower group.
- R7: Control bits 5:0 name an override source and control bit 8 picks its line (1 = high). When that source is pending and unmasked it wins its line over all others, and it never competes as a group member. Ungrouped sources reach a line only this way.
- R8: The routing register is word 3. Group g slot p (1 or 2) has a 2-bit field at bit 4g+(2-p)*2, and the value 2'b01 sends that slot to the high line. Every other value, every other slot and every unslotted source goes to the low line.
- R9: Each line is asserted exactly when its own vector is nonzero, and each vector considers only sources routed to its own line.
- R10: A source change or register write made before a clock edge shows on the vectors and lines right after that edge and not before it.
- R11: Writes to words 4 and 5 change no state. Reads of unmapped words return zero.
- R12: A line stays asserted while its winning source stays asserted and unmasked, and drops one cycle after the source is removed or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_lvl | input | 64 | Level request per source number (bit 0 unused) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_lo | output | 1 | Low CPU interrupt line |
| irq_hi | output | 1 | High CPU interrupt line |

## Verification
Every result of this block is due exactly one clock edge after its cause. A source level is captured by the input sample flop and a register write by its register, and the resolution, vectors and lines follow combinationally from those flops. The bench changes inputs on the falling edge and samples on the next falling edge, so each check sits half a cycle after the edge that should have moved the result. For the timing requirement it also samples a second time before that edge, to confirm the result has not moved early.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
// Shared sizes, register word indices and types for the grouped priority
// interrupt controller. Assumes six groups of eight sources and 3-bit codes.
package prio_irq_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_SRC    = 64;
    localparam int SRC_W      = $clog2(NUM_SRC);
    localparam int NUM_GRP    = 6;
    localparam int GRP_SIZE   = 8;
    localparam int CODE_W     = $clog2(GRP_SIZE);
    localparam int GRP_W      = 3;
    localparam int SLOTS      = 8;
    localparam int SEL_W      = 2;
    localparam int HI_SLOTS   = 2;
    localparam int ROUTE_GRP  = SEL_W * HI_SLOTS;
    localparam int ROUTE_W    = ROUTE_GRP * NUM_GRP;
    localparam int KEY_W      = 1 + CODE_W + GRP_W + GRP_W;
    localparam int ADDR_W     = 4;
    localparam int MASK_WORDS = NUM_SRC / DATA_W;

    // Register word indices
    localparam int A_CTRL  = 0;
    localparam int A_MASK0 = 1;
    localparam int A_ROUTE = 3;
    localparam int A_VLO   = 4;
    localparam int A_VHI   = 5;
    localparam int A_PRIO  = 8;

    // Control word fields
    localparam int HP_LSB      = 0;
    localparam int HP_DEST_BIT = 8;
    localparam int SPREAD_LSB  = 16;
    localparam int VEC_LSB     = DATA_W - SRC_W;

    localparam logic [SEL_W-1:0] ROUTE_HIGH = 2'b01;

    typedef logic [SLOTS-1:0][CODE_W-1:0] slot_codes_t;

    typedef struct packed {
        logic              valid;
        logic [KEY_W-1:0]  key;
        logic [SRC_W-1:0]  src;
    } cand_t;

    // Bit offset of priority slot p (1-based) inside a priority word
    function automatic int slot_lsb(input int p);
        return (p < 4) ? (32 - 3 * p) : (24 - 3 * p);
    endfunction
endpackage

// File: rtl/prio_irq_regs.sv
`timescale 1ns/1ps
// Register file: control, masks, routing and per-group priority slots.
// Only defined fields are stored; reads reassemble them and return zero
// for unmapped words. Vector words are read-only views of the resolvers.
module prio_irq_regs
    import prio_irq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [SRC_W-1:0]            vec_lo,
    input  logic [SRC_W-1:0]            vec_hi,
    output logic [SRC_W-1:0]            hp_src,
    output logic                        hp_dest,
    output logic [NUM_GRP-1:0]          spread,
    output logic [NUM_SRC-1:0]          mask,
    output logic [ROUTE_W-1:0]          route,
    output slot_codes_t [NUM_GRP-1:0]   slot_code
);
    logic [SRC_W-1:0]          hp_q;
    logic                      dest_q;
    logic [NUM_GRP-1:0]        spread_q;
    logic [NUM_SRC-1:0]        mask_q;
    logic [ROUTE_W-1:0]        route_q;
    slot_codes_t [NUM_GRP-1:0] prio_q;

    // Register update on a write strobe; vector words have no storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_q     <= '0;
            dest_q   <= 1'b0;
            spread_q <= '0;
            mask_q   <= '0;
            route_q  <= '0;
            prio_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_CTRL)) begin
                hp_q     <= bus_wdata[HP_LSB +: SRC_W];
                dest_q   <= bus_wdata[HP_DEST_BIT];
                spread_q <= bus_wdata[SPREAD_LSB +: NUM_GRP];
            end
            if (bus_addr == ADDR_W'(A_ROUTE))
                route_q <= bus_wdata[ROUTE_W-1:0];
            for (int i = 0; i < MASK_WORDS; i++)
                if (bus_addr == ADDR_W'(A_MASK0 + i))
                    mask_q[i*DATA_W +: DATA_W] <= bus_wdata;
            for (int g = 0; g < NUM_GRP; g++)
                if (bus_addr == ADDR_W'(A_PRIO + g))
                    for (int p = 0; p < SLOTS; p++)
                        prio_q[g][p] <= bus_wdata[slot_lsb(p + 1) +: CODE_W];
        end
    end

    // Read mux, reassembling stored fields at their word positions
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTRL)) begin
            bus_rdata[HP_LSB +: SRC_W]        = hp_q;
            bus_rdata[HP_DEST_BIT]            = dest_q;
            bus_rdata[SPREAD_LSB +: NUM_GRP]  = spread_q;
        end
        if (bus_addr == ADDR_W'(A_ROUTE))
            bus_rdata[ROUTE_W-1:0] = route_q;
        if (bus_addr == ADDR_W'(A_VLO))
            bus_rdata[VEC_LSB +: SRC_W] = vec_lo;
        if (bus_addr == ADDR_W'(A_VHI))
            bus_rdata[VEC_LSB +: SRC_W] = vec_hi;
        for (int i = 0; i < MASK_WORDS; i++)
            if (bus_addr == ADDR_W'(A_MASK0 + i))
                bus_rdata = mask_q[i*DATA_W +: DATA_W];
        for (int g = 0; g < NUM_GRP; g++)
            if (bus_addr == ADDR_W'(A_PRIO + g))
                for (int p = 0; p < SLOTS; p++)
                    bus_rdata[slot_lsb(p + 1) +: CODE_W] = prio_q[g][p];
    end

    assign hp_src    = hp_q;
    assign hp_dest   = dest_q;
    assign spread    = spread_q;
    assign mask      = mask_q;
    assign route     = route_q;
    assign slot_code = prio_q;

    // R11: writes to the vector words leave all stored state untouched
    assert_vec_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(A_VLO) || bus_addr == ADDR_W'(A_VHI)))
        |=> ($stable(hp_q) && $stable(dest_q) && $stable(spread_q) &&
             $stable(mask_q) && $stable(route_q) && $stable(prio_q)));

    // R2: a write to the low mask word lands in the low mask bits
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_MASK0))
        |=> (mask_q[DATA_W-1:0] == $past(bus_wdata)));
endmodule

// File: rtl/prio_irq_group.sv
`timescale 1ns/1ps
// Resolver for one source group. Finds each code's first slot, decides
// whether it is routed high, builds a comparable rank key and returns the
// best pending candidate for each line. Assumes pend already masked and
// with the override source removed.
module prio_irq_group
    import prio_irq_pkg::*;
#(
    parameter int GRP_IDX = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GRP_SIZE-1:0]     pend,
    input  slot_codes_t             slot_code,
    input  logic [ROUTE_GRP-1:0]    route_fld,
    input  logic                    spread,
    output cand_t                   cand_lo,
    output cand_t                   cand_hi
);
    localparam logic [GRP_W-1:0] GID = GRP_W'(GRP_IDX);

    logic [GRP_SIZE-1:0]              slotted;
    logic [GRP_SIZE-1:0][CODE_W-1:0]  first_slot;
    logic [GRP_SIZE-1:0]              to_hi;
    logic [GRP_SIZE-1:0][KEY_W-1:0]   key;

    // Lowest slot holding each code (scan downward so lowest wins)
    always_comb begin
        for (int c = 0; c < GRP_SIZE; c++) begin
            slotted[c]    = 1'b0;
            first_slot[c] = '0;
            for (int p = SLOTS - 1; p >= 0; p--) begin
                if (slot_code[p] == CODE_W'(c)) begin
                    slotted[c]    = 1'b1;
                    first_slot[c] = CODE_W'(p);
                end
            end
        end
    end

    // Line routing: only the top two slots may select the high line
    always_comb begin
        for (int c = 0; c < GRP_SIZE; c++) begin
            to_hi[c] = slotted[c] &&
                ((first_slot[c] == CODE_W'(0) &&
                  route_fld[SEL_W +: SEL_W] == ROUTE_HIGH) ||
                 (first_slot[c] == CODE_W'(1) &&
                  route_fld[0 +: SEL_W] == ROUTE_HIGH));
        end
    end

    // Rank key: slotted entries first, grouped or spread ordering
    always_comb begin
        for (int c = 0; c < GRP_SIZE; c++) begin
            if (slotted[c])
                key[c] = spread ? {1'b0, first_slot[c], GID, GID}
                                : {1'b0, GID, first_slot[c], GID};
            else
                key[c] = {1'b1, CODE_W'(0), GID, CODE_W'(c)};
        end
    end

    // Best pending candidate per line (lowest key)
    always_comb begin
        cand_lo = '0;
        cand_hi = '0;
        for (int c = 0; c < GRP_SIZE; c++) begin
            if (pend[c]) begin
                if (to_hi[c]) begin
                    if (!cand_hi.valid || key[c] < cand_hi.key) begin
                        cand_hi.valid = 1'b1;
                        cand_hi.key   = key[c];
                        cand_hi.src   = SRC_W'(GRP_SIZE * (GRP_IDX + 1) + c);
                    end
                end else begin
                    if (!cand_lo.valid || key[c] < cand_lo.key) begin
                        cand_lo.valid = 1'b1;
                        cand_lo.key   = key[c];
                        cand_lo.src   = SRC_W'(GRP_SIZE * (GRP_IDX + 1) + c);
                    end
                end
            end
        end
    end

    // R8: a high-line candidate must come from a slotted entry
    assert_hi_slotted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cand_hi.valid |-> !cand_hi.key[KEY_W-1]);

    // R2: no candidate without a pending member
    assert_cand_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_lo.valid || cand_hi.valid) |-> (pend != '0));
endmodule

// File: rtl/prio_irq_pick.sv
`timescale 1ns/1ps
// Final selector for one line: the override source when it applies,
// otherwise the lowest-key group candidate, otherwise zero.
module prio_irq_pick
    import prio_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  cand_t [NUM_GRP-1:0]     cand,
    input  logic                    hp_hit,
    input  logic [SRC_W-1:0]        hp_src,
    output logic [SRC_W-1:0]        vec
);
    logic              found;
    logic [KEY_W-1:0]  best_key;
    logic [SRC_W-1:0]  best_src;

    // Lowest key across the group candidates
    always_comb begin
        found    = 1'b0;
        best_key = '0;
        best_src = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (cand[g].valid && (!found || cand[g].key < best_key)) begin
                found    = 1'b1;
                best_key = cand[g].key;
                best_src = cand[g].src;
            end
        end
    end

    // Override beats every group winner
    always_comb vec = hp_hit ? hp_src : (found ? best_src : '0);

    // R9: a present group candidate always yields a nonzero vector
    assert_vec_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (found || hp_hit) |-> (vec != '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
// Grouped priority interrupt controller top. Samples source levels once,
// masks them, removes the override source from group competition, runs
// one resolver per group and one selector per line. Lines follow
// combinationally from registered state.
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_lvl,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_lo,
    output logic                 irq_hi
);
    logic [NUM_SRC-1:0]         src_q;
    logic [NUM_SRC-1:0]         mask;
    logic [NUM_SRC-1:0]         pend;
    logic [NUM_SRC-1:0]         hp_onehot;
    logic [NUM_SRC-1:0]         grp_pend;
    logic [SRC_W-1:0]           hp_src;
    logic                       hp_dest;
    logic                       hp_valid;
    logic [NUM_GRP-1:0]         spread;
    logic [ROUTE_W-1:0]         route;
    slot_codes_t [NUM_GRP-1:0]  slot_code;
    cand_t [NUM_GRP-1:0]        cand_lo;
    cand_t [NUM_GRP-1:0]        cand_hi;
    logic [SRC_W-1:0]           vec_lo;
    logic [SRC_W-1:0]           vec_hi;

    // Input sample of the level requests; source 0 does not exist
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= {src_lvl[NUM_SRC-1:1], 1'b0};
    end

    prio_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .vec_lo    (vec_lo),
        .vec_hi    (vec_hi),
        .hp_src    (hp_src),
        .hp_dest   (hp_dest),
        .spread    (spread),
        .mask      (mask),
        .route     (route),
        .slot_code (slot_code)
    );

    // Masked pending set and override selection
    always_comb begin
        pend      = src_q & mask;
        hp_onehot = '0;
        if (hp_src != '0) hp_onehot[hp_src] = 1'b1;
        grp_pend  = pend & ~hp_onehot;
        hp_valid  = (hp_src != '0) && pend[hp_src];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        prio_irq_group #(.GRP_IDX(g)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .pend      (grp_pend[GRP_SIZE*(g+1) +: GRP_SIZE]),
            .slot_code (slot_code[g]),
            .route_fld (route[ROUTE_GRP*g +: ROUTE_GRP]),
            .spread    (spread[g]),
            .cand_lo   (cand_lo[g]),
            .cand_hi   (cand_hi[g])
        );
    end

    prio_irq_pick u_pick_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand   (cand_lo),
        .hp_hit (hp_valid && !hp_dest),
        .hp_src (hp_src),
        .vec    (vec_lo)
    );

    prio_irq_pick u_pick_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand   (cand_hi),
        .hp_hit (hp_valid && hp_dest),
        .hp_src (hp_src),
        .vec    (vec_hi)
    );

    assign irq_lo = (vec_lo != '0);
    assign irq_hi = (vec_hi != '0);

    // R2: a reported winner always has its mask bit set
    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_lo != '0) |-> mask[vec_lo]);

    // R7: a live override routed high owns the high vector
    assert_hp_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_src != '0 && src_q[hp_src] && mask[hp_src] && hp_dest)
        |-> (vec_hi == hp_src));

    // R9: the two lines never report the same source
    assert_vec_disjoint_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_lo != '0) |-> (vec_lo != vec_hi));

    // R12: an asserted line is backed by a sampled active source
    assert_irq_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> src_q[vec_hi]);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module prio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src = '0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #0.5;
        d = bus_rdata;
    endtask

    task automatic vec(input int a, output int v);
        logic [31:0] d;
        rd(a, d);
        v = int'(d[31:26]);
    endtask

    // Change one source level; result due after the next edge
    task automatic put(input int n, input logic v);
        @(negedge clk);
        src[n] = v;
        @(negedge clk);
    endtask

    task automatic expect_vecs(input string tag, input int lo, input int hi);
        int v;
        vec(4, v); check({tag, " vec_lo"}, v, lo);
        vec(5, v); check({tag, " vec_hi"}, v, hi);
        check({tag, " irq_lo"}, irq_lo, lo != 0);
        check({tag, " irq_hi"}, irq_hi, hi != 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        @(negedge clk); src = '1; @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            rd(a, d);
            check($sformatf("R1 reset word %0d", a), d, 0);
        end
        check("R1 irq_lo", irq_lo, 0);
        check("R1 irq_hi", irq_hi, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        put(9, 1'b1);
        expect_vecs("R2 masked", 0, 0);
        wr(1, 32'h0000_0200);
        expect_vecs("R2 bit9", 9, 0);
        put(9, 1'b0);
        put(41, 1'b1);
        expect_vecs("R2 hi word off", 0, 0);
        wr(2, 32'h0000_0200);
        expect_vecs("R2 bit41", 41, 0);
        rd(4, d);
        check("R3 vector format", d, 32'(41) << 26);
        rd(2, d);
        check("R2 mask readback", d, 32'h0000_0200);
    endtask

    task automatic t_slots();
        logic [31:0] d;
        do_reset();
        wr(1, '1); wr(2, '1);
        wr(8, 32'hA880_4000);   // slot1=5 slot2=2 slot3=1 slot4=4 others 0
        rd(8, d);
        check("R4 prio readback", d, 32'hA880_4000);
        put(10, 1); put(13, 1);
        expect_vecs("R4 slot1 over slot2", 13, 0);
        put(13, 0);
        expect_vecs("R4 slot2 alone", 10, 0);
        put(10, 0); put(8, 1); put(12, 1);
        expect_vecs("R4 slot4 over slot5", 12, 0);
        put(12, 0); put(15, 1);
        expect_vecs("R4 slotted over unslotted", 8, 0);
        put(8, 0); put(11, 1);
        expect_vecs("R4 unslotted lower code", 11, 0);
        wr(8, 32'hA880_4007);   // slot8 = code 7
        expect_vecs("R4 slot8 field", 15, 0);
    endtask

    task automatic t_grouped();
        do_reset();
        wr(1, '1); wr(2, '1);
        put(16, 1); put(8, 1);
        expect_vecs("R5 W over X", 8, 0);
        put(8, 0); put(24, 1);
        expect_vecs("R5 X over Y", 16, 0);
        put(16, 0); put(24, 0); put(17, 1); put(25, 1);
        expect_vecs("R5 unslotted by group", 17, 0);
        put(24, 1);
        expect_vecs("R5 slotted Y over unslotted X", 24, 0);
    endtask

    task automatic t_spread();
        do_reset();
        wr(1, '1); wr(2, '1);
        wr(9, 32'hD000_0000);   // X: slot1=6 (src22), slot2=4 (src20)
        wr(10, 32'h6000_0000);  // Y: slot1=3 (src27)
        put(20, 1); put(27, 1);
        expect_vecs("R6 grouped baseline", 20, 0);
        wr(0, 32'h0004_0000);   // Y spread
        expect_vecs("R6 Y spread", 27, 0);
        wr(0, 32'h0006_0000);   // X and Y spread
        expect_vecs("R6 both spread", 27, 0);
        put(22, 1);
        expect_vecs("R6 X slot1 spread", 22, 0);
    endtask

    task automatic t_override();
        do_reset();
        wr(1, '1); wr(2, '1);
        put(8, 1); put(60, 1);
        expect_vecs("R7 ungrouped idle", 8, 0);
        wr(0, 32'h0000_003C);
        expect_vecs("R7 override low", 60, 0);
        wr(0, 32'h0000_0108);
        expect_vecs("R7 override high", 0, 8);
        put(9, 1);
        expect_vecs("R7 low keeps group", 9, 8);
        wr(1, 32'hFFFF_FDFF);
        wr(0, 32'h0000_0109);
        expect_vecs("R7 masked override", 8, 0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        do_reset();
        wr(1, '1); wr(2, '1);
        wr(8, 32'hA880_4000);
        wr(3, 32'h0000_0004);   // W slot1 high
        put(10, 1); put(13, 1);
        expect_vecs("R8 slot1 high", 10, 13);
        wr(3, 32'h0000_0005);
        expect_vecs("R8 both slots high", 0, 13);
        wr(3, 32'h0000_000D);   // slot1 code 11 stays low, slot2 high
        expect_vecs("R8 only 01 selects high", 13, 10);
        wr(3, 32'h0000_0040);   // X slot1 high
        put(16, 1);
        expect_vecs("R8 X slot1 high", 13, 16);
        rd(3, d);
        check("R8 route readback", d, 32'h0000_0040);
        put(10, 0); put(13, 0); put(16, 0);
        wr(3, 32'h0055_5555);
        put(9, 1);              // W slot3
        expect_vecs("R8 slot3 stays low", 9, 0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        do_reset();
        wr(1, '1);
        put(8, 1);
        wr(4, '1); wr(5, '1); wr(7, '1); wr(15, '1);
        expect_vecs("R11 vector write ignored", 8, 0);
        rd(0, d);  check("R11 ctrl untouched", d, 0);
        rd(3, d);  check("R11 route untouched", d, 0);
        rd(7, d);  check("R11 unmapped 7", d, 0);
        rd(15, d); check("R11 unmapped 15", d, 0);
    endtask

    task automatic t_timing();
        do_reset();
        wr(1, '1);
        @(negedge clk);
        src[13] = 1'b1;
        #0.5;
        check("R10 before edge", irq_lo, 0);
        @(negedge clk);
        check("R10 after edge", irq_lo, 1);
        repeat (3) @(negedge clk);
        check("R12 held while active", irq_lo, 1);
        src[13] = 1'b0;
        #0.5;
        check("R12 not early", irq_lo, 1);
        @(negedge clk);
        check("R12 drop on release", irq_lo, 0);
        put(13, 1);
        wr(1, 0);
        expect_vecs("R12 drop on mask", 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mask();
        t_slots();
        t_grouped();
        t_spread();
        t_override();
        t_route();
        t_readonly();
        t_timing();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule